// File: doc/BRIEF.md
# Quad-Channel Serial DAC Register Front-End

This block is the digital side of a four-channel 8-bit converter. A host drives a three-wire serial link: a shift clock, a data line and a load line. A separate active-low update strobe is also provided. The block samples all of these with a fast system clock, detects their falling edges, and shifts in 11-bit command words most significant bit first. Each word carries a two-bit channel select, a range bit and an 8-bit code. The outputs are the four codes and the four range bits that the analog cores would consume.

Every channel is double buffered. An input latch takes the word when the load line falls. An output latch drives the converter. If the update strobe is low when the load line falls, the selected output latch is written in the same cycle. If the strobe is high, nothing reaches the outputs until the strobe falls. That falling edge then moves all four input latches to their outputs together. Words longer than 11 bits are allowed, so a host can send two 8-clock bytes; only the final 11 bits count.

Top module: `qdac_front`

## Requirements
- R1: After reset every code output is 0 and every range output is 0. The shift register is cleared too, so a load with no bits shifted after reset writes code 0 with range 0 to channel A.
- R2: A word is 11 bits sent first to last as: select bit 1, select bit 0, range, code bit 7 down to code bit 0. Select value 0 picks channel A (index 0), 1 picks B, 2 picks C and 3 picks D.
- R3: A bit is taken from `ser_din` only on a falling edge of `ser_clk` while `ser_load` is high. Rising edges, and falling edges while `ser_load` is low, leave the shift register unchanged.
- R4: When more than 11 bits are shifted before a load, only the last 11 decide the word.
- R5: With `upd_strobe` low, a falling edge of `ser_load` writes the selected channel's output on the third rising edge of `clk` after the fall. The other channels are not changed.
- R6: While `upd_strobe` is high, no code or range output changes, even when loads take place.
- R7: A falling edge of `upd_strobe` copies all four input latches to the outputs together, on the third rising edge of `clk` after the fall.
- R8: The range bit is stored per channel alongside the code: 0 means 1x and 1 means 2x.
- R9: When `ser_load` and `upd_strobe` fall in the same cycle, the selected channel's output gets the new word. The other channels get their input latches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; at least 8 times the serial clock rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ser_clk | input | 1 | Serial shift clock, asynchronous |
| ser_din | input | 1 | Serial data, sampled on falling edges of ser_clk |
| ser_load | input | 1 | High while shifting; its falling edge loads the word |
| upd_strobe | input | 1 | High holds the outputs; its falling edge updates all channels |
| ch_code | output | 4x8 | Output-latch codes, channel A in bits 7:0 |
| ch_range | output | 4 | Output-latch range bits, channel A in bit 0 |

## Verification
Every external line passes through two synchronizer flops and one edge register. An output therefore changes on the third rising edge of `clk` after `ser_load` or `upd_strobe` falls. One test checks this directly: it confirms the old value just after the second edge and the new value just after the third. Every other result is queued by the driver only after six edges have passed with the inputs quiet. The monitor compares it on the next falling edge of `clk`, so no sample lands in the update window.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
  localparam int unsigned QD_CODE_W      = 8;
  localparam int unsigned QD_SEL_W       = 2;
  localparam int unsigned QD_SYNC_STAGES = 2;

  // bit positions of the edge-detected control lines
  localparam int unsigned IDX_SCLK = 0;
  localparam int unsigned IDX_LOAD = 1;
  localparam int unsigned IDX_UPD  = 2;
  localparam int unsigned N_CTRL   = 3;
endpackage

// File: rtl/qdac_sync.sv
module qdac_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] stg_d [STAGES];

  always_comb begin
    stg_d[0] = async_in;
    for (int k = 1; k < STAGES; k++) stg_d[k] = stg_q[k-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) stg_q[k] <= '0;
    end else begin
      for (int k = 0; k < STAGES; k++) stg_q[k] <= stg_d[k];
    end
  end

  assign sync_out = stg_q[STAGES-1];
endmodule

// File: rtl/qdac_fall.sv
module qdac_fall #(
  parameter int unsigned W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] fall
);
  logic [W-1:0] prev_q;
  logic [W-1:0] prev_d;

  assign prev_d = lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end

  assign fall = prev_q & ~lvl;
endmodule

// File: rtl/qdac_shifter.sv
module qdac_shifter #(
  parameter int unsigned WORD_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              din,
  output logic [WORD_W-1:0] word
);
  logic [WORD_W-1:0] word_q;
  logic [WORD_W-1:0] word_d;

  always_comb begin
    word_d = word_q;
    if (shift_en) word_d = {word_q[WORD_W-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_d;
  end

  assign word = word_q;

  // R3: no qualified edge, no movement
  assert_shift_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(word_q));
  // R2: each bit enters at the bottom, older bits move toward the top
  assert_msb_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (word_q[0] == $past(din)) &&
                 (word_q[WORD_W-1:1] == $past(word_q[WORD_W-2:0])));
endmodule

// File: rtl/qdac_chan.sv
module qdac_chan #(
  parameter int unsigned CH_W = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            direct,
  input  logic            commit,
  input  logic [CH_W-1:0] wr_word,
  output logic [CH_W-1:0] out_word
);
  logic [CH_W-1:0] in_q, in_d;
  logic [CH_W-1:0] out_q, out_d;
  logic            wr_direct;

  assign wr_direct = wr_en & direct;

  always_comb begin
    in_d = in_q;
    if (wr_en) in_d = wr_word;
  end

  always_comb begin
    out_d = out_q;
    if (wr_direct)   out_d = wr_word;
    else if (commit) out_d = in_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q  <= '0;
      out_q <= '0;
    end else begin
      in_q  <= in_d;
      out_q <= out_d;
    end
  end

  assign out_word = out_q;

  // R6: without a direct write or a commit the output latch holds
  assert_out_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_direct && !commit) |=> $stable(out_q));
  // R7: a commit moves the previous input-latch content
  assert_commit_copy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !wr_direct) |=> out_q == $past(in_q));
  // R5, R9: a direct write wins, including over a coincident commit
  assert_direct_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_direct |=> out_q == $past(wr_word));
  // R8: the input latch takes code and range together
  assert_in_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> in_q == $past(wr_word));
endmodule

// File: rtl/qdac_front.sv
module qdac_front
  import qdac_pkg::*;
#(
  parameter int unsigned CODE_W      = QD_CODE_W,
  parameter int unsigned SEL_W       = QD_SEL_W,
  parameter int unsigned SYNC_STAGES = QD_SYNC_STAGES
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                ser_clk,
  input  logic                                ser_din,
  input  logic                                ser_load,
  input  logic                                upd_strobe,
  output logic [(1<<SEL_W)-1:0][CODE_W-1:0]   ch_code,
  output logic [(1<<SEL_W)-1:0]               ch_range
);
  localparam int unsigned NCH    = 1 << SEL_W;
  localparam int unsigned CH_W   = CODE_W + 1;
  localparam int unsigned WORD_W = SEL_W + CH_W;
  localparam int unsigned SYNC_W = N_CTRL + 1;

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_i_n = rst_q[1];

  // synchronizers: control lines in low bits, data on top
  logic [SYNC_W-1:0] raw_in, syn;
  logic [N_CTRL-1:0] ctl_lvl, ctl_fall;

  always_comb begin
    raw_in                 = '0;
    raw_in[IDX_SCLK]       = ser_clk;
    raw_in[IDX_LOAD]       = ser_load;
    raw_in[IDX_UPD]        = upd_strobe;
    raw_in[SYNC_W-1]       = ser_din;
  end

  qdac_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .async_in (raw_in),
    .sync_out (syn)
  );

  assign ctl_lvl = syn[N_CTRL-1:0];

  qdac_fall #(.W(N_CTRL)) u_fall (
    .clk   (clk),
    .rst_n (rst_i_n),
    .lvl   (ctl_lvl),
    .fall  (ctl_fall)
  );

  // shift path
  logic              shift_en;
  logic [WORD_W-1:0] word;

  assign shift_en = ctl_fall[IDX_SCLK] & ctl_lvl[IDX_LOAD];

  qdac_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .shift_en (shift_en),
    .din      (syn[SYNC_W-1]),
    .word     (word)
  );

  // decode
  logic [SEL_W-1:0] sel;
  logic [CH_W-1:0]  payload;
  logic             load_evt, commit, direct;
  logic [NCH-1:0]   wr_sel;

  assign sel      = word[WORD_W-1 -: SEL_W];
  assign payload  = word[CH_W-1:0];
  assign load_evt = ctl_fall[IDX_LOAD];
  assign commit   = ctl_fall[IDX_UPD];
  assign direct   = ~ctl_lvl[IDX_UPD];

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [CH_W-1:0] ch_out;

    assign wr_sel[i] = load_evt && (sel == SEL_W'(i));

    qdac_chan #(.CH_W(CH_W)) u_chan (
      .clk      (clk),
      .rst_n    (rst_i_n),
      .wr_en    (wr_sel[i]),
      .direct   (direct),
      .commit   (commit),
      .wr_word  (payload),
      .out_word (ch_out)
    );

    assign ch_code[i]  = ch_out[CODE_W-1:0];
    assign ch_range[i] = ch_out[CODE_W];
  end

  // R2: at most one channel is written per cycle
  assert_sel_onehot_R2: assert property (@(posedge clk) disable iff (!rst_i_n)
    $onehot0(wr_sel));
  // R5: every load event reaches exactly one channel
  assert_load_hits_one_R5: assert property (@(posedge clk) disable iff (!rst_i_n)
    load_evt |-> $countones(wr_sel) == 1);
  // R6: while the strobe is held high, the port outputs do not move
  assert_port_hold_R6: assert property (@(posedge clk) disable iff (!rst_i_n)
    (ctl_lvl[IDX_UPD] && $past(ctl_lvl[IDX_UPD])) |=> ($stable(ch_code) && $stable(ch_range)));
endmodule

// File: tb/qdac_front_test.sv
module qdac_front_test;
  localparam int CLK_P = 10;
  localparam int NCH   = 4;
  localparam int CW    = 8;

  logic clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic rst_n, ser_clk, ser_din, ser_load, upd_strobe;
  logic [NCH-1:0][CW-1:0] ch_code;
  logic [NCH-1:0]         ch_range;

  qdac_front uut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_din(ser_din),
    .ser_load(ser_load), .upd_strobe(upd_strobe),
    .ch_code(ch_code), .ch_range(ch_range)
  );

  typedef struct { logic [35:0] v; string tag; } exp_t;
  exp_t sb_q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done  = 0;
  logic [8:0] m_in  [NCH];
  logic [8:0] m_out [NCH];

  function automatic logic [35:0] model_vec();
    logic [35:0] r;
    for (int i = 0; i < NCH; i++) begin
      r[i*8 +: 8] = m_out[i][7:0];
      r[32 + i]   = m_out[i][8];
    end
    return r;
  endfunction

  task automatic compare(input logic [35:0] e, input string tag);
    n_chk++;
    if ({ch_range, ch_code} !== e) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, {ch_range, ch_code}, e);
    end
  endtask

  // monitor: pops expected items and compares away from the rising edge
  always @(negedge clk) begin
    exp_t e;
    if (sb_q.size() != 0) begin
      e = sb_q.pop_front();
      compare(e.v, e.tag);
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_model(input string tag);
    repeat (6) @(posedge clk);
    #1;
    sb_q.push_back('{model_vec(), tag});
    idle(2);
  endtask

  task automatic shift_bits(input logic [31:0] b, input int n);
    for (int k = n - 1; k >= 0; k--) begin
      @(negedge clk);
      ser_din = b[k];
      ser_clk = 1'b1;
      idle(4);
      ser_clk = 1'b0;
      idle(4);
    end
  endtask

  task automatic load_pulse();
    @(negedge clk) ser_load = 1'b0;
    idle(5);
    ser_load = 1'b1;
    idle(5);
  endtask

  task automatic model_load(input logic [1:0] sel, input logic rng, input logic [7:0] code);
    m_in[sel] = {rng, code};
    if (!upd_strobe) m_out[sel] = m_in[sel];
  endtask

  task automatic write_ch(input logic [1:0] sel, input logic rng, input logic [7:0] code);
    shift_bits({21'd0, sel, rng, code}, 11);
    load_pulse();
    model_load(sel, rng, code);
  endtask

  task automatic model_reset();
    for (int i = 0; i < NCH; i++) begin
      m_in[i]  = '0;
      m_out[i] = '0;
    end
  endtask

  initial begin
    rst_n = 1'b0; ser_clk = 1'b0; ser_din = 1'b0; ser_load = 1'b1; upd_strobe = 1'b0;
    model_reset();
    idle(4);
    compare(model_vec(), "R1 outputs during reset");
    @(negedge clk) rst_n = 1'b1;
    expect_model("R1 reset state");

    // R5: exact latency of a direct load
    shift_bits({21'd0, 2'd0, 1'b1, 8'h3C}, 11);
    @(negedge clk) ser_load = 1'b0;
    @(posedge clk); @(posedge clk); #1;
    compare(model_vec(), "R5 unchanged after second edge");
    @(posedge clk); #1;
    model_load(2'd0, 1'b1, 8'h3C);
    compare(model_vec(), "R5 updated on third edge");
    idle(3);
    ser_load = 1'b1;
    idle(5);

    // R2 / R8: each select value and both ranges
    write_ch(2'd1, 1'b1, 8'hC3);
    expect_model("R2 channel B select 01 range 1");
    write_ch(2'd2, 1'b0, 8'h01);
    expect_model("R2 channel C select 10");
    write_ch(2'd3, 1'b1, 8'hFF);
    expect_model("R8 channel D range 1");
    write_ch(2'd0, 1'b0, 8'hA5);
    expect_model("R8 channel A range back to 0");

    // R3: edges while load is low do not shift; reload gives same word
    write_ch(2'd2, 1'b1, 8'h66);
    @(negedge clk) ser_load = 1'b0;
    idle(3);
    for (int k = 0; k < 11; k++) begin
      @(negedge clk) ser_din = 1'b0; ser_clk = 1'b1;
      idle(4);
      ser_clk = 1'b0;
      idle(4);
    end
    ser_load = 1'b1;
    idle(5);
    load_pulse();
    expect_model("R3 shifts ignored while load low");

    // R4: 16 bits, first five are junk ones
    shift_bits({16'd0, 5'b11111, 2'd3, 1'b0, 8'h42}, 16);
    load_pulse();
    model_load(2'd3, 1'b0, 8'h42);
    expect_model("R4 last eleven bits kept");

    // R6: loads with strobe high do not touch outputs
    @(negedge clk) upd_strobe = 1'b1;
    idle(5);
    write_ch(2'd0, 1'b1, 8'h11);
    expect_model("R6 hold after load to A");
    write_ch(2'd1, 1'b0, 8'h22);
    expect_model("R6 hold after load to B");

    // R7: strobe fall moves all input latches
    @(negedge clk) upd_strobe = 1'b0;
    for (int i = 0; i < NCH; i++) m_out[i] = m_in[i];
    expect_model("R7 all channels updated together");

    // R9: coincident load and strobe falls
    @(negedge clk) upd_strobe = 1'b1;
    idle(5);
    write_ch(2'd2, 1'b0, 8'h9E);
    shift_bits({21'd0, 2'd3, 1'b1, 8'h7B}, 11);
    @(negedge clk) begin ser_load = 1'b0; upd_strobe = 1'b0; end
    m_in[3] = {1'b1, 8'h7B};
    for (int i = 0; i < NCH; i++) m_out[i] = m_in[i];
    idle(5);
    ser_load = 1'b1;
    expect_model("R9 selected gets new word, others copy");

    // R1: reset clears outputs and shift register
    @(negedge clk) rst_n = 1'b0;
    model_reset();
    idle(2);
    compare(model_vec(), "R1 asynchronous clear");
    @(negedge clk) rst_n = 1'b1;
    idle(5);
    load_pulse();
    expect_model("R1 empty shift register writes zero to A");

    done = 1'b1;
    idle(3);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run hung, actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule